// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block steps through a multi-register memory transfer. A 16-bit list names which word registers take part. A caller presents the list together with a base address, a two-bit addressing mode, a writeback flag, a direction flag and a status-restore flag. The block then counts the selected registers and works out the first address. After that it issues one word request per accepted cycle, from the lowest selected register index to the highest, and the address rises by one word after each accepted request.

When the last request has been accepted, the block reports the final address for a base writeback. If the transfer is a load and the list includes the program counter (index 15), the block captures the response word returned with that request. It splits that word into an instruction-set select bit and a halfword-aligned counter value. It also flags whether the status register must be restored from its saved copy. Moving data to or from the register file is left to the surrounding pipeline.

Top module: `lsm_sequencer`

## Requirements
- R1: Mode 0 (increment-after) starts at the base address. Mode 1 (increment-before) starts at base + 4.
- R2: Mode 2 (decrement-after) starts at base − 4·n + 4. Mode 3 (decrement-before) starts at base − 4·n. Here n is the number of set bits in the list.
- R3: A non-empty list produces exactly one request per set bit. Requests go out in rising index order, and each accepted request raises the next address by 4.
- R4: While `req_valid_o` is high and `req_ready_i` is low, the request stays valid, and its address, index and direction do not change.
- R5: In the done cycle, `wb_en_o` equals the latched writeback flag. `wb_value_o` equals the first address plus 4·n, which is the address left after the last transfer.
- R6: A start with an empty list makes no request. It raises `done_o` in the next cycle with `wb_value_o` equal to the base.
- R7: `done_o` is high for exactly the one cycle after the last request is accepted. `req_valid_o` is low in that cycle.
- R8: A start presented while `busy_o` is high has no effect on the running transfer.
- R9: For a load whose list has bit 15 set, `pc_wr_o` is high in the done cycle. `isa_sel_o` then equals bit 0 of the response word accepted with the index-15 request, and `pc_value_o` equals that word with bit 0 cleared. `pc_wr_o` is low for stores and for lists without bit 15.
- R10: `status_restore_o` is high in the done cycle only for a load with the status-restore flag set and bit 15 in the list.
- R11: Under reset, `busy_o`, `req_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| list_i | input | 16 | Register selection list |
| base_i | input | 32 | Base address |
| mode_i | input | 2 | Addressing mode (0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before) |
| wback_i | input | 1 | Base writeback requested |
| load_i | input | 1 | 1 = load (read), 0 = store (write) |
| sflag_i | input | 1 | Status-restore flag |
| busy_o | output | 1 | Transfer in progress |
| req_valid_o | output | 1 | Memory request valid |
| req_write_o | output | 1 | Request is a write |
| req_addr_o | output | 32 | Request word address |
| req_idx_o | output | 4 | Register index of the request |
| req_ready_i | input | 1 | Memory accepts the request this cycle |
| rsp_data_i | input | 32 | Read data returned with an accepted load request |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Base writeback enable (valid with done) |
| wb_value_o | output | 32 | New base value |
| pc_wr_o | output | 1 | Program counter load this transfer |
| pc_value_o | output | 32 | Loaded counter value, bit 0 cleared |
| isa_sel_o | output | 1 | Instruction-set select taken from bit 0 |
| status_restore_o | output | 1 | Restore status from saved copy |

## Verification
A wrong remaining-list mask shows up at `req_idx_o` on the very next request. It can also show as a missing or extra request before `done_o`, so the error is visible within one accepted cycle. A wrong address register, or a wrong first-address computation, shows on `req_addr_o` at the first request and again in `wb_value_o` at the end. Stalls from `req_ready_i` are varied so that any update made without acceptance breaks the order or the address step at once. Latched flags only appear in the done cycle, so they are compared there for every transfer.

// File: rtl/lsm_pkg.sv
// Package: shared types for the block transfer sequencer.
// Assumes: two-bit addressing mode as decoded by the instruction front end.
package lsm_pkg;

    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'd0,
        AM_INC_BEFORE = 2'd1,
        AM_DEC_AFTER  = 2'd2,
        AM_DEC_BEFORE = 2'd3
    } addr_mode_e;

endpackage

// File: rtl/lsm_popcount.sv
// Module: counts the set bits of a selection vector.
// Assumes: CW is wide enough to hold N.
module lsm_popcount #(
    parameter int N  = 16,
    parameter int CW = 5
) (
    input  logic [N-1:0]  vec_i,
    output logic [CW-1:0] count_o
);

    // Purpose: accumulate one per set bit.
    always_comb begin
        count_o = '0;
        for (int i = 0; i < N; i++) begin
            count_o = count_o + CW'(vec_i[i]);
        end
    end

endmodule

// File: rtl/lsm_start_addr.sv
// Module: derives first and final transfer addresses from base, mode and count.
// Assumes: modular address arithmetic; an empty list keeps the base as final.
module lsm_start_addr
    import lsm_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CW   = 5,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] base_i,
    input  addr_mode_e    mode_i,
    input  logic [CW-1:0] count_i,
    output logic [AW-1:0] first_o,
    output logic [AW-1:0] final_o
);

    logic [AW-1:0] span;
    logic [AW-1:0] step_w;

    assign step_w = AW'(STEP);
    assign span   = AW'(count_i) * step_w;

    // Purpose: select the first address for each addressing mode.
    always_comb begin
        unique case (mode_i)
            AM_INC_AFTER:  first_o = base_i;
            AM_INC_BEFORE: first_o = base_i + step_w;
            AM_DEC_AFTER:  first_o = base_i - span + step_w;
            default:       first_o = base_i - span;
        endcase
    end

    // Purpose: address left after the last transfer, base when nothing moves.
    always_comb begin
        if (count_i == '0) final_o = base_i;
        else               final_o = first_o + span;
    end

endmodule

// File: rtl/lsm_lowest.sv
// Module: finds the lowest set bit of a vector and whether it is the only one.
// Assumes: idx_o is meaningless when any_o is low.
module lsm_lowest #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o,
    output logic          single_o
);

    // Purpose: priority scan, lowest index wins.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end

    assign any_o    = |vec_i;
    assign single_o = any_o && ((vec_i & (vec_i - N'(1))) == '0);

endmodule

// File: rtl/lsm_sequencer.sv
// Module: block transfer address sequencer (top).
// Takes a start when idle, then issues one word request per accepted cycle,
// in rising register order, and pulses done with writeback and counter results.
// Assumes: rsp_data_i is valid in the cycle a load request is accepted.
module lsm_sequencer
    import lsm_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 16,
    parameter int STEP = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [NREG-1:0]           list_i,
    input  logic [AW-1:0]             base_i,
    input  logic [1:0]                mode_i,
    input  logic                      wback_i,
    input  logic                      load_i,
    input  logic                      sflag_i,
    output logic                      busy_o,
    output logic                      req_valid_o,
    output logic                      req_write_o,
    output logic [AW-1:0]             req_addr_o,
    output logic [$clog2(NREG)-1:0]   req_idx_o,
    input  logic                      req_ready_i,
    input  logic [AW-1:0]             rsp_data_i,
    output logic                      done_o,
    output logic                      wb_en_o,
    output logic [AW-1:0]             wb_value_o,
    output logic                      pc_wr_o,
    output logic [AW-1:0]             pc_value_o,
    output logic                      isa_sel_o,
    output logic                      status_restore_o
);

    localparam int IW     = $clog2(NREG);
    localparam int CW     = $clog2(NREG + 1);
    localparam int PC_IDX = NREG - 1;

    logic [NREG-1:0] remain_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   final_q;
    logic [AW-1:0]   pc_q;
    logic            busy_q, done_q, load_q, sflag_q, wback_q, has_pc_q, isa_q;

    logic [CW-1:0]   count;
    logic [AW-1:0]   first_addr, final_addr;
    logic [IW-1:0]   cur_idx;
    logic            cur_any, cur_single;
    logic            start_take, req_take, last_take;

    lsm_popcount #(.N(NREG), .CW(CW)) u_count (
        .vec_i   (list_i),
        .count_o (count)
    );

    lsm_start_addr #(.AW(AW), .CW(CW), .STEP(STEP)) u_addr (
        .base_i  (base_i),
        .mode_i  (addr_mode_e'(mode_i)),
        .count_i (count),
        .first_o (first_addr),
        .final_o (final_addr)
    );

    lsm_lowest #(.N(NREG), .IW(IW)) u_pick (
        .vec_i    (remain_q),
        .idx_o    (cur_idx),
        .any_o    (cur_any),
        .single_o (cur_single)
    );

    assign start_take = start_i && !busy_q;
    assign req_take   = busy_q && req_ready_i;
    assign last_take  = req_take && cur_single;

    // Purpose: transfer state, address stepping and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            addr_q   <= '0;
            final_q  <= '0;
            pc_q     <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            load_q   <= 1'b0;
            sflag_q  <= 1'b0;
            wback_q  <= 1'b0;
            has_pc_q <= 1'b0;
            isa_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_take) begin
                remain_q <= list_i;
                addr_q   <= first_addr;
                final_q  <= final_addr;
                load_q   <= load_i;
                sflag_q  <= sflag_i;
                wback_q  <= wback_i;
                has_pc_q <= list_i[PC_IDX];
                busy_q   <= |list_i;
                done_q   <= ~|list_i;
            end else if (req_take) begin
                remain_q <= remain_q & (remain_q - NREG'(1));
                addr_q   <= addr_q + AW'(STEP);
                if (load_q && cur_idx == IW'(PC_IDX)) begin
                    pc_q  <= {rsp_data_i[AW-1:1], 1'b0};
                    isa_q <= rsp_data_i[0];
                end
                if (cur_single) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o           = busy_q;
    assign req_valid_o      = busy_q && cur_any;
    assign req_write_o      = !load_q;
    assign req_addr_o       = addr_q;
    assign req_idx_o        = cur_idx;
    assign done_o           = done_q;
    assign wb_en_o          = done_q && wback_q;
    assign wb_value_o       = final_q;
    assign pc_wr_o          = done_q && load_q && has_pc_q;
    assign pc_value_o       = pc_q;
    assign isa_sel_o        = isa_q;
    assign status_restore_o = done_q && load_q && sflag_q && has_pc_q;

    // R4: a stalled request holds still
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
                                        && $stable(req_idx_o) && $stable(req_write_o));

    // R3: accepted non-final request advances the address by one word
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        req_take && !cur_single |=> req_addr_o == $past(req_addr_o) + AW'(STEP));

    // R3: register order strictly rises
    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        req_take && !cur_single |=> req_idx_o > $past(req_idx_o));

    // R8: a start while busy does not end or restart the transfer
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !last_take |=> busy_o);

    // R7: no request in the done cycle
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !req_valid_o);

    // R6: empty list finishes at once without a request
    a_r6_empty: assert property (@(posedge clk) disable iff (!rst_n)
        start_take && list_i == '0 |=> done_o && !req_valid_o);

endmodule

// File: tb/test_lsm_sequencer.sv
// Bench: behavioural reference model with queues, compared on every clock.
module test_lsm_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] list_i = '0;
    logic [31:0] base_i = '0;
    logic [1:0]  mode_i = '0;
    logic        wback_i = 1'b0, load_i = 1'b0, sflag_i = 1'b0;
    logic        busy_o, req_valid_o, req_write_o;
    logic [31:0] req_addr_o;
    logic [3:0]  req_idx_o;
    logic        req_ready_i = 1'b0;
    logic [31:0] rsp_data_i = '0;
    logic        done_o, wb_en_o, pc_wr_o, isa_sel_o, status_restore_o;
    logic [31:0] wb_value_o, pc_value_o;

    lsm_sequencer i_lsm_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .list_i(list_i),
        .base_i(base_i), .mode_i(mode_i), .wback_i(wback_i), .load_i(load_i),
        .sflag_i(sflag_i), .busy_o(busy_o), .req_valid_o(req_valid_o),
        .req_write_o(req_write_o), .req_addr_o(req_addr_o), .req_idx_o(req_idx_o),
        .req_ready_i(req_ready_i), .rsp_data_i(rsp_data_i), .done_o(done_o),
        .wb_en_o(wb_en_o), .wb_value_o(wb_value_o), .pc_wr_o(pc_wr_o),
        .pc_value_o(pc_value_o), .isa_sel_o(isa_sel_o),
        .status_restore_o(status_restore_o)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit checking = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int          q_idx[$];
    logic [31:0] q_addr[$];
    bit          m_busy, m_done, m_load, m_s, m_wb, m_pc_in, m_isa, m_first, m_empty;
    logic [31:0] m_final, m_pc;
    logic [1:0]  m_mode;

    int          ready_mode = 0;
    bit          data_fixed = 1'b0;
    logic [31:0] data_val = 32'h0;
    logic [31:0] lfsr = 32'h1234_5678;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // model: mirrors the requirements at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            q_idx.delete(); q_addr.delete();
            m_busy = 0; m_done = 0;
        end else begin
            bit nd;
            nd = 0;
            if (m_busy) begin
                if (req_ready_i) begin
                    int r;
                    r = q_idx.pop_front();
                    void'(q_addr.pop_front());
                    m_first = 0;
                    if (r == 15 && m_load) begin
                        m_pc  = {rsp_data_i[31:1], 1'b0};
                        m_isa = rsp_data_i[0];
                    end
                    if (q_idx.size() == 0) begin m_busy = 0; nd = 1; end
                end
            end else if (start_i) begin
                int n;
                logic [31:0] a;
                n = $countones(list_i);
                case (mode_i)
                    2'd0: a = base_i;
                    2'd1: a = base_i + 4;
                    2'd2: a = base_i - 32'(4 * n) + 4;
                    default: a = base_i - 32'(4 * n);
                endcase
                for (int i = 0; i < 16; i++) begin
                    if (list_i[i]) begin
                        q_idx.push_back(i); q_addr.push_back(a); a = a + 4;
                    end
                end
                m_final = (n == 0) ? base_i : a;
                m_load = load_i; m_s = sflag_i; m_wb = wback_i;
                m_pc_in = list_i[15]; m_mode = mode_i;
                m_first = 1; m_empty = (n == 0);
                if (n == 0) nd = 1; else m_busy = 1;
            end
            m_done = nd;
        end
    end

    // compare, then drive ready and response data, away from the rising edge
    always @(negedge clk) begin
        if (checking) begin
            bit ev;
            ev = m_busy;
            check(busy_o == m_busy, "R8", 32'(busy_o), 32'(m_busy));
            check(req_valid_o == ev, "R7", 32'(req_valid_o), 32'(ev));
            if (ev && req_valid_o) begin
                string atag;
                atag = m_first ? ((m_mode < 2) ? "R1" : "R2") : "R3";
                check(req_addr_o == q_addr[0], atag, req_addr_o, q_addr[0]);
                check(int'(req_idx_o) == q_idx[0], "R3", 32'(req_idx_o), 32'(q_idx[0]));
                check(req_write_o == !m_load, "R4", 32'(req_write_o), 32'(!m_load));
            end
            check(done_o == m_done, m_empty ? "R6" : "R7", 32'(done_o), 32'(m_done));
            if (m_done && done_o) begin
                check(wb_en_o == m_wb, "R5", 32'(wb_en_o), 32'(m_wb));
                check(wb_value_o == m_final, m_empty ? "R6" : "R5", wb_value_o, m_final);
                check(pc_wr_o == (m_load && m_pc_in), "R9", 32'(pc_wr_o),
                      32'(m_load && m_pc_in));
                if (m_load && m_pc_in) begin
                    check(pc_value_o == m_pc, "R9", pc_value_o, m_pc);
                    check(isa_sel_o == m_isa, "R9", 32'(isa_sel_o), 32'(m_isa));
                end
                check(status_restore_o == (m_load && m_s && m_pc_in), "R10",
                      32'(status_restore_o), 32'(m_load && m_s && m_pc_in));
            end
        end
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        case (ready_mode)
            0: req_ready_i = 1'b1;
            1: req_ready_i = cycles[0];
            default: req_ready_i = lfsr[3] | lfsr[9];
        endcase
        rsp_data_i = data_fixed ? data_val : lfsr;
    end

    task automatic run_op(input logic [15:0] l, input logic [31:0] b, input logic [1:0] m,
                          input bit wb, input bit ld, input bit s);
        @(negedge clk);
        list_i = l; base_i = b; mode_i = m; wback_i = wb; load_i = ld; sflag_i = s;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (m_busy || m_done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(busy_o == 1'b0, "R11", 32'(busy_o), 32'h0);
        check(req_valid_o == 1'b0, "R11", 32'(req_valid_o), 32'h0);
        check(done_o == 1'b0, "R11", 32'(done_o), 32'h0);
        rst_n = 1'b1;
        checking = 1'b1;

        ready_mode = 0;
        run_op(16'h00F1, 32'h0000_1000, 2'd0, 1, 0, 0);   // R1 inc-after store
        ready_mode = 1;
        run_op(16'h8003, 32'h0000_2000, 2'd1, 1, 1, 1);   // R1 R9 R10
        ready_mode = 2;
        run_op(16'h0F0F, 32'h0000_3000, 2'd2, 0, 1, 0);   // R2 dec-after
        data_fixed = 1'b1; data_val = 32'h0800_0101;
        run_op(16'hFFFF, 32'h0000_0100, 2'd3, 1, 1, 0);   // R2 R9 odd word
        data_val = 32'h0000_4442;
        run_op(16'h8000, 32'h0000_0010, 2'd3, 1, 1, 1);   // R9 even word, R10
        run_op(16'h8001, 32'h0000_0040, 2'd0, 1, 0, 1);   // R9 R10 store: no pc
        data_fixed = 1'b0;
        run_op(16'h0007, 32'h0000_0008, 2'd3, 1, 0, 0);   // R2 wrap below zero
        run_op(16'h0000, 32'hABCD_0000, 2'd2, 1, 1, 1);   // R6 empty list
        run_op(16'h0000, 32'h0000_7777, 2'd1, 0, 0, 0);   // R6 empty, no wb

        // R8: second start during a stalled transfer is dropped
        ready_mode = 1;
        @(negedge clk);
        list_i = 16'h0330; base_i = 32'h0000_5000; mode_i = 2'd1;
        wback_i = 1; load_i = 0; sflag_i = 0; start_i = 1'b1;
        @(negedge clk);
        list_i = 16'hFFFF; base_i = 32'h0000_9000; mode_i = 2'd3; load_i = 1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        while (m_busy || m_done) @(negedge clk);

        ready_mode = 2;
        for (int k = 0; k < 40; k++) begin
            run_op(lfsr[15:0], lfsr ^ 32'h5A5A_0000, lfsr[17:16], lfsr[20], lfsr[21],
                   lfsr[22]);
        end
        repeat (2) @(negedge clk);
        checking = 1'b0;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        if (!finished && cycles > 150000) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule